// File: doc/BRIEF.md
# Multicore Local Interrupt Router

This block gathers the interrupt sources that belong to each of four processor cores and turns them into one IRQ line and one FIQ line per core. Every core has four timer lines and four mailbox-pending flags of its own. A single IRQ/FIQ pair from the graphics subsystem is shared, and each half of that pair is steered to exactly one core that software picks. Two 8-bit control words per core, one for the timer lines and one for the mailbox flags, decide for each local source whether it raises the core's IRQ, its FIQ, or nothing. When both enables of a source are set, FIQ wins.

The router keeps a registered IRQ status word and a registered FIQ status word per core. Both are rebuilt on every clock from the live inputs, so a source that drops also leaves the status one clock later. A core's output is the OR of its status word. Software configures the block and reads the status words through a plain 32-bit word-addressed register port, with byte offsets on an 8-bit address. Read data appears one clock after the read strobe and holds until the next read. Every pin is a level or a one-cycle strobe, so no flow control or back-pressure applies. The core count is a parameter of at most four.

Top module: `lirq_router`

## Requirements
- R1: In a core's status words, timer source n (0..3) sits at bit n, mailbox source n at bit 4+n and the graphics source at bit 8. Bits 9 to 31 always read zero.
- R2: In a control word, bit n enables IRQ delivery of local source n and bit n+4 enables FIQ delivery. A source with neither bit set reaches neither status word.
- R3: A source whose FIQ enable is set appears only in the FIQ status, whatever its IRQ enable holds.
- R4: The routing word at offset 0x0C holds the IRQ core number in bits [1:0] and the FIQ core number in bits [3:2], and reads back in that packing. The graphics IRQ (FIQ) sets bit 8 of the IRQ (FIQ) status of the selected core only, and no control word masks it.
- R5: Timer control words are at 0x40+4*core and mailbox control words at 0x50+4*core. A write keeps wdata[7:0], and a read returns that value with bits 31:8 zero.
- R6: IRQ status is read at 0x60+4*core and FIQ status at 0x70+4*core. Writes to these offsets change nothing.
- R7: Status words and outputs follow the inputs and control words with one clock of latency and are not latched. Each core output is high exactly when its status word is nonzero.
- R8: An access to an unmapped offset, or to an address with nonzero bits [1:0], reads zero and its write changes nothing.
- R9: Reset clears the routing fields, all control words, all status words, the outputs and the read data.
- R10: cfg_rdata takes the addressed value on the clock edge where cfg_rd_en is sampled high. It returns the value the registers held before any write on that same edge, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Byte offset of the access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| tmr_irq | input | NUM_CORES*4 | Timer lines, core c source n at bit 4c+n |
| mbx_pend | input | NUM_CORES*4 | Mailbox-pending flags, core c mailbox n at bit 4c+n |
| gpu_irq | input | 1 | Shared graphics IRQ |
| gpu_fiq | input | 1 | Shared graphics FIQ |
| core_irq | output | NUM_CORES | IRQ line per core |
| core_fiq | output | NUM_CORES | FIQ line per core |

## Verification
A wrong control or routing bit shows up one clock after its source next asserts: a core line comes up that should stay low, a line stays low, or an event lands on IRQ instead of FIQ. A stuck or stale status bit shows on the core outputs within one clock and in the status readback two clocks after the read is issued. The bench keeps an independent model of the registers and status words and compares both core output vectors and the read data on every clock. A corrupted register therefore appears in the first cycle in which any source or read touches it.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LOCAL_SRCS = 4;
  localparam int unsigned CTRL_W     = 2 * LOCAL_SRCS;
  localparam int unsigned TMR_LSB    = 0;
  localparam int unsigned MBX_LSB    = LOCAL_SRCS;
  localparam int unsigned GPU_BIT    = 8;

  localparam logic [ADDR_W-1:0] ROUTE_OFS = 8'h0C;
  localparam logic [3:0] TCTL_PAGE = 4'h4;
  localparam logic [3:0] MCTL_PAGE = 4'h5;
  localparam logic [3:0] IST_PAGE  = 4'h6;
  localparam logic [3:0] FST_PAGE  = 4'h7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_TCTL,
    SEL_MCTL,
    SEL_IST,
    SEL_FST
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] idx;
  } reg_dec_t;

  // Shared by the write path and the read path so both see one map.
  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned ncores);
    reg_dec_t d;
    d.sel = SEL_NONE;
    d.idx = a[3:2];
    if (a[1:0] == 2'b00) begin
      if (a == ROUTE_OFS) begin
        d.sel = SEL_ROUTE;
      end else if (32'(a[3:2]) < ncores) begin
        if (a[7:4] == TCTL_PAGE)      d.sel = SEL_TCTL;
        else if (a[7:4] == MCTL_PAGE) d.sel = SEL_MCTL;
        else if (a[7:4] == IST_PAGE)  d.sel = SEL_IST;
        else if (a[7:4] == FST_PAGE)  d.sel = SEL_FST;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/lirq_cfg_regs.sv
module lirq_cfg_regs
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [CTRL_W-1:0] tctl [NUM_CORES],
  output logic [CTRL_W-1:0] mctl [NUM_CORES],
  output logic [CORE_W-1:0] route_irq,
  output logic [CORE_W-1:0] route_fiq
);

  reg_dec_t wdec;
  assign wdec = decode_addr(addr, NUM_CORES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_irq <= '0;
      route_fiq <= '0;
    end else if (wr_en && wdec.sel == SEL_ROUTE) begin
      route_irq <= wdata[CORE_W-1:0];
      route_fiq <= wdata[2*CORE_W-1:CORE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        tctl[c] <= '0;
        mctl[c] <= '0;
      end
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (wdec.sel == SEL_TCTL && wdec.idx == 2'(c)) tctl[c] <= wdata[CTRL_W-1:0];
        if (wdec.sel == SEL_MCTL && wdec.idx == 2'(c)) mctl[c] <= wdata[CTRL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lirq_steer.sv
module lirq_steer
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 2
) (
  input  logic [LOCAL_SRCS-1:0] tmr [NUM_CORES],
  input  logic [LOCAL_SRCS-1:0] mbx [NUM_CORES],
  input  logic                  gpu_irq,
  input  logic                  gpu_fiq,
  input  logic [CTRL_W-1:0]     tctl [NUM_CORES],
  input  logic [CTRL_W-1:0]     mctl [NUM_CORES],
  input  logic [CORE_W-1:0]     route_irq,
  input  logic [CORE_W-1:0]     route_fiq,
  output logic [WORD_W-1:0]     irq_nxt [NUM_CORES],
  output logic [WORD_W-1:0]     fiq_nxt [NUM_CORES]
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [WORD_W-1:0] iw;
    logic [WORD_W-1:0] fw;

    always_comb begin
      iw = '0;
      fw = '0;
      for (int n = 0; n < LOCAL_SRCS; n++) begin
        // FIQ enable wins; IRQ only when FIQ enable is clear.
        fw[TMR_LSB+n] = tmr[c][n] & tctl[c][n+LOCAL_SRCS];
        iw[TMR_LSB+n] = tmr[c][n] & tctl[c][n] & ~tctl[c][n+LOCAL_SRCS];
        fw[MBX_LSB+n] = mbx[c][n] & mctl[c][n+LOCAL_SRCS];
        iw[MBX_LSB+n] = mbx[c][n] & mctl[c][n] & ~mctl[c][n+LOCAL_SRCS];
      end
      fw[GPU_BIT] = gpu_fiq & (route_fiq == CORE_W'(c));
      iw[GPU_BIT] = gpu_irq & (route_irq == CORE_W'(c));
    end

    assign irq_nxt[c] = iw;
    assign fiq_nxt[c] = fw;
  end

endmodule

// File: rtl/lirq_status.sv
module lirq_status
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    irq_nxt [NUM_CORES],
  input  logic [WORD_W-1:0]    fiq_nxt [NUM_CORES],
  output logic [WORD_W-1:0]    irq_stat [NUM_CORES],
  output logic [WORD_W-1:0]    fiq_stat [NUM_CORES],
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        irq_stat[c] <= '0;
        fiq_stat[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        irq_stat[c] <= irq_nxt[c];
        fiq_stat[c] <= fiq_nxt[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      core_irq[c] = |irq_stat[c];
      core_fiq[c] = |fiq_stat[c];
    end
  end

endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr_en,
  input  logic                           cfg_rd_en,
  input  logic [7:0]                     cfg_addr,
  input  logic [31:0]                    cfg_wdata,
  output logic [31:0]                    cfg_rdata,
  input  logic [NUM_CORES*4-1:0]         tmr_irq,
  input  logic [NUM_CORES*4-1:0]         mbx_pend,
  input  logic                           gpu_irq,
  input  logic                           gpu_fiq,
  output logic [NUM_CORES-1:0]           core_irq,
  output logic [NUM_CORES-1:0]           core_fiq
);

  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [LOCAL_SRCS-1:0] tmr [NUM_CORES];
  logic [LOCAL_SRCS-1:0] mbx [NUM_CORES];
  logic [CTRL_W-1:0]     tctl [NUM_CORES];
  logic [CTRL_W-1:0]     mctl [NUM_CORES];
  logic [CORE_W-1:0]     route_irq;
  logic [CORE_W-1:0]     route_fiq;
  logic [WORD_W-1:0]     irq_nxt [NUM_CORES];
  logic [WORD_W-1:0]     fiq_nxt [NUM_CORES];
  logic [WORD_W-1:0]     irq_stat [NUM_CORES];
  logic [WORD_W-1:0]     fiq_stat [NUM_CORES];
  logic [WORD_W-1:0]     rd_word;
  reg_dec_t              rdec;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_split
    assign tmr[c] = tmr_irq[c*LOCAL_SRCS +: LOCAL_SRCS];
    assign mbx[c] = mbx_pend[c*LOCAL_SRCS +: LOCAL_SRCS];
  end

  lirq_cfg_regs #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .tctl      (tctl),
    .mctl      (mctl),
    .route_irq (route_irq),
    .route_fiq (route_fiq)
  );

  lirq_steer #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_steer (
    .tmr       (tmr),
    .mbx       (mbx),
    .gpu_irq   (gpu_irq),
    .gpu_fiq   (gpu_fiq),
    .tctl      (tctl),
    .mctl      (mctl),
    .route_irq (route_irq),
    .route_fiq (route_fiq),
    .irq_nxt   (irq_nxt),
    .fiq_nxt   (fiq_nxt)
  );

  lirq_status #(.NUM_CORES(NUM_CORES)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_nxt  (irq_nxt),
    .fiq_nxt  (fiq_nxt),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat),
    .core_irq (core_irq),
    .core_fiq (core_fiq)
  );

  assign rdec = decode_addr(cfg_addr, NUM_CORES);

  always_comb begin
    rd_word = '0;
    unique case (rdec.sel)
      SEL_ROUTE: rd_word[2*CORE_W-1:0] = {route_fiq, route_irq};
      SEL_TCTL:  rd_word[CTRL_W-1:0]   = tctl[rdec.idx];
      SEL_MCTL:  rd_word[CTRL_W-1:0]   = mctl[rdec.idx];
      SEL_IST:   rd_word               = irq_stat[rdec.idx];
      SEL_FST:   rd_word               = fiq_stat[rdec.idx];
      default:   rd_word               = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_rdata <= '0;
    else if (cfg_rd_en) cfg_rdata <= rd_word;
  end

endmodule

// File: rtl/lirq_router_chk.sv
module lirq_router_chk
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_rd_en,
  input logic [7:0]             cfg_addr,
  input logic [31:0]            cfg_rdata,
  input logic [NUM_CORES*4-1:0] tmr_irq,
  input logic [NUM_CORES*4-1:0] mbx_pend,
  input logic                   gpu_irq,
  input logic                   gpu_fiq,
  input logic [NUM_CORES-1:0]   core_irq,
  input logic [NUM_CORES-1:0]   core_fiq,
  input logic [WORD_W-1:0]      irq_stat [NUM_CORES],
  input logic [WORD_W-1:0]      fiq_stat [NUM_CORES],
  input logic [CORE_W-1:0]      route_irq
);

  logic [NUM_CORES-1:0] gpu_irq_col;
  logic [NUM_CORES-1:0] gpu_fiq_col;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      gpu_irq_col[c] = irq_stat[c][GPU_BIT];
      gpu_fiq_col[c] = fiq_stat[c][GPU_BIT];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    // R3
    fiq_precedence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat[c][7:0] & fiq_stat[c][7:0]) == 8'h00);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat[c][31:9] == '0) && (fiq_stat[c][31:9] == '0));
  end

  // R4
  gpu_single_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_irq_col) && $onehot0(gpu_fiq_col));

  // R4
  gpu_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpu_irq |=> core_irq[$past(route_irq)]);

  // R7
  quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq == '0 && mbx_pend == '0 && !gpu_irq && !gpu_fiq)
      |=> (core_irq == '0 && core_fiq == '0));

  // R8
  unaligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && cfg_addr[1:0] != 2'b00) |=> cfg_rdata == 32'h0);

  // R5
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && cfg_addr[7:5] == 3'b010) |=> cfg_rdata[31:CTRL_W] == '0);

endmodule

bind lirq_router lirq_router_chk #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rd_en (cfg_rd_en),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .tmr_irq   (tmr_irq),
  .mbx_pend  (mbx_pend),
  .gpu_irq   (gpu_irq),
  .gpu_fiq   (gpu_fiq),
  .core_irq  (core_irq),
  .core_fiq  (core_fiq),
  .irq_stat  (irq_stat),
  .fiq_stat  (fiq_stat),
  .route_irq (route_irq)
);

// File: tb/test_lirq_router.sv
module test_lirq_router;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] tmr_irq = '0;
  logic [15:0] mbx_pend = '0;
  logic        gpu_irq = 1'b0;
  logic        gpu_fiq = 1'b0;
  logic [3:0]  core_irq;
  logic [3:0]  core_fiq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  logic [7:0]  m_t  [NC];
  logic [7:0]  m_m  [NC];
  logic [1:0]  m_ri, m_rf;
  logic [31:0] m_is [NC];
  logic [31:0] m_fs [NC];
  logic [31:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  lirq_router #(.NUM_CORES(NC)) i_lirq_router (
    .clk, .rst_n, .cfg_wr_en, .cfg_rd_en, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .tmr_irq, .mbx_pend, .gpu_irq, .gpu_fiq, .core_irq, .core_fiq
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [7:0] a);
    int i;
    i = (int'(a) % 16) / 4;
    if (int'(a) % 4 != 0) return 32'h0;
    if (a == 8'h0C) return {28'h0, m_rf, m_ri};
    if (a >= 8'h40 && a < 8'h50) return {24'h0, m_t[i]};
    if (a >= 8'h50 && a < 8'h60) return {24'h0, m_m[i]};
    if (a >= 8'h60 && a < 8'h70) return m_is[i];
    if (a >= 8'h70 && a < 8'h80) return m_fs[i];
    return 32'h0;
  endfunction

  task automatic model_edge();
    logic [31:0] ni [NC];
    logic [31:0] nf [NC];
    int i;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_t[c] = 0; m_m[c] = 0; m_is[c] = 0; m_fs[c] = 0;
      end
      m_ri = 0; m_rf = 0; m_rd = 0;
      return;
    end
    for (int c = 0; c < NC; c++) begin
      ni[c] = 0; nf[c] = 0;
      for (int n = 0; n < 4; n++) begin
        if (tmr_irq[c*4+n]) begin
          if (m_t[c][n+4]) nf[c][n] = 1;
          else if (m_t[c][n]) ni[c][n] = 1;
        end
        if (mbx_pend[c*4+n]) begin
          if (m_m[c][n+4]) nf[c][n+4] = 1;
          else if (m_m[c][n]) ni[c][n+4] = 1;
        end
      end
      if (gpu_irq && int'(m_ri) == c) ni[c][8] = 1;
      if (gpu_fiq && int'(m_rf) == c) nf[c][8] = 1;
    end
    if (cfg_rd_en) m_rd = mread(cfg_addr);
    if (cfg_wr_en && int'(cfg_addr) % 4 == 0) begin
      i = (int'(cfg_addr) % 16) / 4;
      if (cfg_addr == 8'h0C) begin
        m_ri = cfg_wdata[1:0]; m_rf = cfg_wdata[3:2];
      end else if (cfg_addr >= 8'h40 && cfg_addr < 8'h50) m_t[i] = cfg_wdata[7:0];
      else if (cfg_addr >= 8'h50 && cfg_addr < 8'h60) m_m[i] = cfg_wdata[7:0];
    end
    for (int c = 0; c < NC; c++) begin
      m_is[c] = ni[c]; m_fs[c] = nf[c];
    end
  endtask

  task automatic cyc();
    logic [3:0] ei, ef;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      ei[c] = (m_is[c] != 0);
      ef[c] = (m_fs[c] != 0);
    end
    check("R7 core_irq vs model", {28'h0, core_irq}, {28'h0, ei});
    check("R7 core_fiq vs model", {28'h0, core_fiq}, {28'h0, ef});
    check("R10 cfg_rdata vs model", cfg_rdata, m_rd);
    cfg_wr_en = 0;
    cfg_rd_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    cyc();
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    cfg_rd_en = 1; cfg_addr = a;
    cyc();
    check(tag, cfg_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    check("R9 outputs after reset", {24'h0, core_fiq, core_irq}, 32'h0);
    rst_n = 1;
    cyc();
    rd_chk(8'h0C, 32'h0, "R9 route cleared");
    rd_chk(8'h40, 32'h0, "R9 timer ctrl cleared");
    rd_chk(8'h54, 32'h0, "R9 mailbox ctrl cleared");

    // all timer sources of core 0 to IRQ
    wr(8'h40, 32'h0000_000F);
    tmr_irq = 16'h000F;
    cyc();
    check("R1 R2 core0 irq line", {28'h0, core_irq}, 32'h1);
    rd_chk(8'h60, 32'h0000_000F, "R1 R2 core0 irq status");

    // core 1: src0 both enables, src1 FIQ only
    wr(8'h44, 32'h0000_00F1);
    tmr_irq = 16'h003F;
    cyc();
    rd_chk(8'h64, 32'h0, "R3 core1 irq status empty");
    rd_chk(8'h74, 32'h3, "R3 core1 fiq status");
    wr(8'h44, 32'h0000_0002);
    cyc();
    rd_chk(8'h64, 32'h2, "R2 core1 src0 masked");
    rd_chk(8'h74, 32'h0, "R2 core1 fiq cleared");

    // core 2 mailboxes 0 and 3 to FIQ
    wr(8'h58, 32'h0000_0090);
    mbx_pend = 16'h0900;
    cyc();
    rd_chk(8'h78, 32'h90, "R1 core2 mailbox fiq bits");
    rd_chk(8'h68, 32'h0, "R1 core2 mailbox irq empty");

    wr(8'h4C, 32'hFFFF_FF33);
    rd_chk(8'h4C, 32'h33, "R5 timer ctrl low byte");
    wr(8'h5C, 32'hABCD_12C5);
    rd_chk(8'h5C, 32'hC5, "R5 mailbox ctrl low byte");
    wr(8'h4C, 32'h0);
    wr(8'h5C, 32'h0);

    // graphics IRQ to core 2, FIQ to core 1
    wr(8'h0C, 32'hFFFF_FFF6);
    rd_chk(8'h0C, 32'h6, "R4 route readback");
    gpu_irq = 1; gpu_fiq = 1;
    cyc();
    check("R4 core_irq with gpu", {28'h0, core_irq}, 32'h7);
    check("R4 core_fiq with gpu", {28'h0, core_fiq}, 32'h6);
    rd_chk(8'h68, 32'h100, "R4 gpu irq on core2");
    rd_chk(8'h60, 32'h0F, "R4 core0 no gpu bit");
    rd_chk(8'h74, 32'h100, "R4 gpu fiq on core1");
    rd_chk(8'h7C, 32'h0, "R4 core3 no gpu fiq");

    // all sources drop
    tmr_irq = 0; mbx_pend = 0; gpu_irq = 0; gpu_fiq = 0;
    cyc();
    check("R7 outputs follow inputs", {24'h0, core_fiq, core_irq}, 32'h0);

    // writes that must change nothing
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd_chk(8'h40, 32'h0F, "R8 timer ctrl core0 intact");
    rd_chk(8'h44, 32'h02, "R8 timer ctrl core1 intact");
    rd_chk(8'h0C, 32'h6, "R8 route intact");
    rd_chk(8'h41, 32'h0, "R8 unaligned read zero");
    rd_chk(8'h80, 32'h0, "R8 unmapped read zero");
    rd_chk(8'h60, 32'h0, "R6 status write ignored");
    tmr_irq = 16'h0004;
    cyc();
    rd_chk(8'h60, 32'h4, "R6 status tracks input");

    // read and write on the same edge returns old value
    cfg_rd_en = 1; cfg_wr_en = 1; cfg_addr = 8'h48; cfg_wdata = 32'h55;
    cyc();
    check("R10 read returns pre-write value", cfg_rdata, 32'h0);
    cyc();
    check("R10 rdata holds between reads", cfg_rdata, 32'h0);

    // mid-run reset
    rst_n = 0;
    cyc();
    rst_n = 1;
    rd_chk(8'h40, 32'h0, "R9 reset clears ctrl");
    rd_chk(8'h0C, 32'h0, "R9 reset clears route");
    check("R9 masked after reset", {28'h0, core_irq}, 32'h0);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] picks [10];
      picks = '{8'h0C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h41};
      tmr_irq  = 16'($urandom);
      mbx_pend = 16'($urandom);
      gpu_irq  = 1'($urandom);
      gpu_fiq  = 1'($urandom);
      if ($urandom % 3 == 0) begin
        cfg_wr_en = 1;
        cfg_addr  = picks[$urandom % 10];
        cfg_wdata = $urandom;
      end
      if ($urandom % 2 == 0) begin
        cfg_rd_en = 1;
        if (!cfg_wr_en) cfg_addr = 8'($urandom);
      end
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule